// File: doc/BRIEF.md
# Dual-Mode Bus Routing Selector

This block produces the gate-control and clamp signals that route one channel into a bank of 32 mix buses. The buses are served by two groups of 16 gates. Group 0 feeds the odd-numbered buses and group 1 feeds the even-numbered ones. Each group has one shared input node. A 4-bit address selects one gate position inside each group. Two enable lines, A and B, decide which groups conduct. Only the control logic is modelled: the analog switching and its levels lie outside the block.

A strap that is sampled only while reset is held chooses one of two meanings for the enable lines. In pair mode, A drives the left (odd) side and B drives the right (even) side, each on its own, so one address reaches an adjacent odd/even pair. In single mode, B acts as the top bit of a 5-bit destination and A is the master on/off switch, so exactly one of the 32 buses is reached.

When a group's selection changes, the old gate turns off and stays off for a fixed dead time before the new gate turns on. While a group has no gate on, its clamp holds the idle input node at ground. Bus numbers 1..32 map to `bus_gate_o` bits 0..31.

Top module: `bus_route_selector`

## Requirements
- R1: While reset is held, and in the first cycle after it, all 32 gate outputs are low and both clamps are high.
- R2: Bit 2k of `bus_gate_o` is gate k of group 0, and bit 2k+1 is gate k of group 1. At most one gate per group is ever high.
- R3: Pair mode (strap 0) with address n: A alone drives bit 2n, B alone drives bit 2n+1, both drive both bits, and neither leaves every bit low.
- R4: Single mode (strap 1) with address n: when A is high, B=0 drives bit 2n and B=1 drives bit 2n+1. When A is low, no bit is high. At most one bit of the 32 is ever high.
- R5: Inputs are registered on a rising edge. When no dead time is pending, a new gate rises on the second rising edge after the inputs are presented.
- R6: When a group's selection changes, its old gate falls one edge after the change is registered. Any gate of that group rises no sooner than GAP_CYCLES cycles after the group's last gate fell (default 2). The gate that rises is the one named by the registered inputs when the dead time ends.
- R7: A group's clamp is high exactly while none of its gates is high. It rises in the same cycle the gate falls and falls in the same cycle a gate rises.
- R8: Dropping the enables does not lose the address. Raising them again with the same address restores the same destination after the dead time.
- R9: The strap is captured only while reset is held. A change to the strap while running has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap_i | input | 1 | Routing mode, 0 pair, 1 single; captured during reset |
| addr_i | input | 4 | Gate position within a group |
| en_a_i | input | 1 | Left enable (pair) or master enable (single) |
| en_b_i | input | 1 | Right enable (pair) or group select bit (single) |
| bus_gate_o | output | 32 | One gate enable per bus, interleaved by group |
| clamp_o | output | 2 | Ground clamp for each group's input node |

## Verification
The hard case is a change of selection that arrives while a group is still in its dead time. This includes a disable followed by a re-enable inside the gap, and an address change during the gap. In that case a new target is registered in the same cycle the gap counter is deciding whether to turn a gate on. The bench holds inputs for random runs of one to five cycles, which are shorter and longer than the gap, in both modes. A behavioural model tracks the dead time per group. Every cycle, the gate vector and the clamps must match the model. This confirms that only the latest target turns on, that it turns on exactly when the gap ends, and that the clamp changes in that same cycle.

// File: rtl/bus_route_pkg.sv
package bus_route_pkg;
  typedef enum logic {
    MODE_PAIR   = 1'b0,
    MODE_SINGLE = 1'b1
  } route_mode_e;

  localparam int GROUPS = 2;
endpackage

// File: rtl/route_input_stage.sv
module route_input_stage
  import bus_route_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  output route_mode_e       mode_o,
  output logic [GROUPS-1:0] tgt_on_o,
  output logic [ADDR_W-1:0] tgt_sel_o
);
  route_mode_e       mode_r;
  logic [ADDR_W-1:0] addr_r;
  logic              a_r, b_r;

  // strap captured only in reset; address held regardless of enables
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= route_mode_e'(mode_strap_i);
      addr_r <= '0;
      a_r    <= 1'b0;
      b_r    <= 1'b0;
    end else begin
      addr_r <= addr_i;
      a_r    <= en_a_i;
      b_r    <= en_b_i;
    end
  end

  always_comb begin
    if (mode_r == MODE_PAIR) begin
      tgt_on_o = {b_r, a_r};
    end else begin
      tgt_on_o = {a_r & b_r, a_r & ~b_r};
    end
  end

  assign tgt_sel_o = addr_r;
  assign mode_o    = mode_r;
endmodule

// File: rtl/route_group_seq.sv
module route_group_seq #(
  parameter int GATES      = 16,
  parameter int GAP_CYCLES = 2,
  localparam int SEL_W     = $clog2(GATES),
  localparam int CNT_W     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tgt_on_i,
  input  logic [SEL_W-1:0] tgt_sel_i,
  output logic [GATES-1:0] gate_o,
  output logic             clamp_o
);
  logic [GATES-1:0] tgt_oh;
  logic [GATES-1:0] gate_r, gate_nx;
  logic [CNT_W-1:0] gap_r, gap_nx;

  always_comb begin
    tgt_oh = '0;
    if (tgt_on_i) tgt_oh[tgt_sel_i] = 1'b1;
  end

  // break-before-make: any mismatch drops the gate, then waits the gap
  always_comb begin
    gate_nx = gate_r;
    gap_nx  = gap_r;
    if (gate_r != '0 && gate_r != tgt_oh) begin
      gate_nx = '0;
      gap_nx  = CNT_W'(GAP_CYCLES - 1);
    end else if (gate_r == '0 && tgt_oh != '0 && gap_r == '0) begin
      gate_nx = tgt_oh;
    end else if (gap_r != '0) begin
      gap_nx = gap_r - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_r  <= '0;
      gap_r   <= '0;
      clamp_o <= 1'b1;
    end else begin
      gate_r  <= gate_nx;
      gap_r   <= gap_nx;
      clamp_o <= (gate_nx == '0);
    end
  end

  assign gate_o = gate_r;
endmodule

// File: rtl/bus_route_selector.sv
module bus_route_selector
  import bus_route_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int GAP_CYCLES = 2,
  localparam int GATES     = 1 << ADDR_W,
  localparam int BUSES     = GATES * GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_a_i,
  input  logic              en_b_i,
  output logic [BUSES-1:0]  bus_gate_o,
  output logic [GROUPS-1:0] clamp_o
);
  route_mode_e       mode_r;
  logic [GROUPS-1:0] tgt_on;
  logic [ADDR_W-1:0] tgt_sel;
  logic [GATES-1:0]  grp_gate [GROUPS];

  route_input_stage #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst(rst), .mode_strap_i(mode_strap_i), .addr_i(addr_i),
    .en_a_i(en_a_i), .en_b_i(en_b_i), .mode_o(mode_r),
    .tgt_on_o(tgt_on), .tgt_sel_o(tgt_sel)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    route_group_seq #(.GATES(GATES), .GAP_CYCLES(GAP_CYCLES)) u_seq (
      .clk(clk), .rst(rst), .tgt_on_i(tgt_on[g]), .tgt_sel_i(tgt_sel),
      .gate_o(grp_gate[g]), .clamp_o(clamp_o[g])
    );
    for (genvar i = 0; i < GATES; i++) begin : g_map
      assign bus_gate_o[i*GROUPS + g] = grp_gate[g][i];
    end
  end
endmodule

// File: rtl/bus_route_checker.sv
module bus_route_checker #(
  parameter int GATES      = 16,
  parameter int GAP_CYCLES = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [2*GATES-1:0] bus_gate,
  input logic [1:0]         clamp,
  input logic               mode
);
  logic [GATES-1:0] grp [2];
  always_comb begin
    for (int i = 0; i < GATES; i++) begin
      grp[0][i] = bus_gate[2*i];
      grp[1][i] = bus_gate[2*i+1];
    end
  end

  assert_single_total_R4: assert property (@(posedge clk) disable iff (rst)
    mode |-> ($countones(bus_gate) <= 1));

  for (genvar g = 0; g < 2; g++) begin : g_chk
    int   idle_run;
    logic seen_on;
    always_ff @(posedge clk) begin
      if (rst) begin
        idle_run <= 0;
        seen_on  <= 1'b0;
      end else if (grp[g] != '0) begin
        idle_run <= 0;
        seen_on  <= 1'b1;
      end else if (idle_run < GAP_CYCLES) begin
        idle_run <= idle_run + 1;
      end
    end

    assert_onehot_group_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grp[g]));
    assert_clamp_idle_R7: assert property (@(posedge clk) disable iff (rst)
      clamp[g] == (grp[g] == '0));
    assert_no_direct_swap_R6: assert property (@(posedge clk) disable iff (rst)
      (grp[g] != '0) |=> (grp[g] == '0 || grp[g] == $past(grp[g])));
    assert_gap_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (seen_on && grp[g] == '0 && idle_run < GAP_CYCLES - 1) |=> (grp[g] == '0));
  end
endmodule

bind bus_route_selector bus_route_checker #(.GATES(GATES), .GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .bus_gate(bus_gate_o), .clamp(clamp_o), .mode(mode_r)
);

// File: tb/bus_route_selector_tb.sv
module bus_route_selector_tb;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap = 1'b0;
  logic [3:0]  addr = '0;
  logic        ena = 1'b0, enb = 1'b0;
  logic [31:0] bus_gate;
  logic [1:0]  clamp;

  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R1";

  int m_mode, m_addr, m_a, m_b;
  int m_sel [2];
  int m_cnt [2];
  int lfsr = 32'h1d2c3b4a;

  always #2 clk = ~clk;

  bus_route_selector #(.ADDR_W(4), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .mode_strap_i(strap), .addr_i(addr),
    .en_a_i(ena), .en_b_i(enb), .bus_gate_o(bus_gate), .clamp_o(clamp)
  );

  // behavioural reference: registered inputs, then per-group dead-time tracking
  always @(posedge clk) begin
    if (rst) begin
      m_mode = strap; m_addr = 0; m_a = 0; m_b = 0;
      for (int g = 0; g < 2; g++) begin m_sel[g] = -1; m_cnt[g] = 0; end
    end else begin
      for (int g = 0; g < 2; g++) begin
        int on, tgt;
        if (m_mode == 0) on = (g == 0) ? m_a : m_b;
        else             on = (g == 0) ? (m_a && !m_b) : (m_a && m_b);
        tgt = on ? m_addr : -1;
        if (m_sel[g] != -1 && m_sel[g] != tgt) begin
          m_sel[g] = -1; m_cnt[g] = GAP - 1;
        end else if (m_sel[g] == -1 && tgt != -1 && m_cnt[g] == 0) begin
          m_sel[g] = tgt;
        end else if (m_cnt[g] > 0) begin
          m_cnt[g] = m_cnt[g] - 1;
        end
      end
      m_addr = addr; m_a = ena; m_b = enb;
    end
  end

  function automatic logic [31:0] model_bus();
    logic [31:0] v = '0;
    for (int g = 0; g < 2; g++) if (m_sel[g] >= 0) v[2*m_sel[g] + g] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(cur_req, bus_gate, model_bus());
      check({cur_req, " R7 clamp"}, {30'd0, clamp},
            {30'd0, m_sel[1] == -1, m_sel[0] == -1});
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(int a, logic ea, logic eb);
    addr = 4'(a); ena = ea; enb = eb;
  endtask

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr & 32'h7fffffff;
  endfunction

  task automatic do_reset(logic s);
    rst = 1'b1; strap = s; drive(0, 0, 0);
    hold(3);
    check("R1 gates in reset", bus_gate, 32'd0);
    check("R1 clamps in reset", {30'd0, clamp}, 32'd3);
    rst = 1'b0;
    hold(1);
    check("R1 gates after reset", bus_gate, 32'd0);
  endtask

  task automatic random_run(int iters);
    for (int k = 0; k < iters; k++) begin
      int r = rnd();
      drive(r % 16, r[5], r[6]);
      hold(1 + (r >> 8) % 5);
    end
  endtask

  initial begin
    // pair mode
    do_reset(1'b0);
    cur_req = "R3";
    drive(5, 1, 0); hold(1);
    check("R5 not yet on after one edge", bus_gate, 32'd0);
    hold(1);
    check("R5 R3 left side on", bus_gate, 32'd1 << 10);
    drive(5, 1, 1); hold(6);
    check("R3 both sides", bus_gate, (32'd1 << 10) | (32'd1 << 11));
    drive(5, 0, 1); hold(6);
    check("R3 right only", bus_gate, 32'd1 << 11);
    drive(9, 0, 1); hold(2);
    check("R6 gap after change", bus_gate, 32'd0);
    hold(1);
    check("R6 gap still low", bus_gate, 32'd0);
    hold(1);
    check("R6 new gate after gap", bus_gate, 32'd1 << 19);
    drive(9, 0, 0); hold(6);
    check("R3 all off", bus_gate, 32'd0);
    check("R7 clamps high when off", {30'd0, clamp}, 32'd3);
    cur_req = "R8";
    drive(9, 0, 1); hold(6);
    check("R8 resume same destination", bus_gate, 32'd1 << 19);
    cur_req = "R6 R2";
    random_run(400);

    // single mode, strap toggled mid-run
    do_reset(1'b1);
    cur_req = "R4";
    drive(3, 1, 0); hold(6);
    check("R4 B low -> bit 2n", bus_gate, 32'd1 << 6);
    drive(3, 1, 1); hold(6);
    check("R4 B high -> bit 2n+1", bus_gate, 32'd1 << 7);
    drive(3, 0, 1); hold(6);
    check("R4 master off", bus_gate, 32'd0);
    cur_req = "R9";
    strap = 1'b0;
    drive(12, 1, 1); hold(6);
    check("R9 strap change ignored", bus_gate, 32'd1 << 25);
    cur_req = "R4 R6";
    random_run(400);

    // back to pair mode after a reset picks up the strap
    do_reset(1'b0);
    cur_req = "R9";
    drive(12, 1, 1); hold(6);
    check("R9 strap taken at reset", bus_gate, (32'd1 << 24) | (32'd1 << 25));
    hold(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule